// File: doc/BRIEF.md
# Peripheral Channel Address and Reply Responder

This block sits on the device side of a shared parallel I/O channel. A channel master places a 16-bit address word and a data word on the bus and raises a read or write strobe. Every attached device compares a four-bit equipment field of the address word with its own strap-set number. Only the device whose number matches takes any part in the exchange. The lowest address bit picks one of two paths. With the bit clear, the exchange moves one data word between the channel and a device-specific source or sink. With the bit set, a write loads the device's function register and a read returns the device's status word.

The responder answers every exchange it owns with exactly one of two signals: a reply, meaning the word was accepted or is on the bus, or a reject. The reject covers four cases: the unit is not ready, the unit is write-protected and the master does not grant protected access, no data word is waiting, or the sink is full. A status read is always answered with a reply, so the master can find out why other requests fail. The answer comes a fixed, parameter-set number of cycles after the strobe rises. The answer is held for as long as the strobe stays high. On reads, the data lines stay driven for one cycle after the reply falls.

Top module: `chan_responder`

## Requirements
- R1: The equipment code is address bits 10:7 and is compared with `dev_num_i`. Bits 15:11 and bits 6:1 have no effect. An unmatched device never raises `reply_o`, `reject_o` or `dat_oe_o`, and never strobes its source, its sink or its function register.
- R2: Address bit 0 is the director bit. A write with bit 0 = 0 hands `dat_i` to the sink through a one-cycle `snk_valid_o` pulse carrying the word on `snk_data_o`. A write with bit 0 = 1 loads `dat_i` into `func_o`.
- R3: Take the negedge that drives the strobe as cycle 0. An accepted read drives `dat_oe_o` from cycle RESP_DLY+1 and raises `reply_o` at cycle RESP_DLY+2. An accepted write and any reject answer at cycle RESP_DLY+1.
- R4: `reply_o` and `reject_o` stay high while the strobe stays high. Each falls one cycle after the strobe falls.
- R5: After a read, `dat_oe_o` stays high for exactly one cycle after `reply_o` falls and then goes low.
- R6: A data read with `src_valid_i` low is rejected and pops nothing. A data write with `snk_ready_i` low is rejected and strobes no sink.
- R7: With `dev_ready_i` low, data reads, data writes and function writes are rejected. A status read is still answered with a reply.
- R8: With `dev_protected_i` high and `prot_allow_i` low, every access except a status read is rejected. With `prot_allow_i` high, protection has no effect.
- R9: A status read returns `status_i` on `dat_o`. A data read returns the source word on `dat_o` and asserts `src_ready_o` for exactly one cycle.
- R10: During a data read, `char_o` is high when the word's bits 15:8 are zero and low otherwise. When BYTE_ONLY is set, the source word's bits 15:8 are forced to zero. `char_o` is low for status reads.
- R11: `reply_o` and `reject_o` are never high together.
- R12: After reset, `reply_o`, `reject_o`, `dat_oe_o`, `char_o`, `src_ready_o` and `snk_valid_o` are low and `func_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 16 | Channel address word |
| rd_i | input | 1 | Read strobe from the master |
| wr_i | input | 1 | Write strobe from the master |
| prot_allow_i | input | 1 | Master grants access to protected units |
| dat_i | input | 16 | Word written by the master |
| dat_o | output | 16 | Word driven toward the master |
| dat_oe_o | output | 1 | Data lines are driven |
| reply_o | output | 1 | Request accepted |
| reject_o | output | 1 | Request refused |
| char_o | output | 1 | Transfer uses only the low byte |
| dev_num_i | input | 4 | Strap-set equipment number |
| dev_ready_i | input | 1 | Unit is ready |
| dev_protected_i | input | 1 | Unit is write-protected |
| status_i | input | 16 | Status word of the unit |
| src_valid_i | input | 1 | Source holds a word |
| src_data_i | input | 16 | Source word |
| src_ready_o | output | 1 | Source word consumed (one cycle) |
| snk_ready_i | input | 1 | Sink can take a word |
| snk_valid_o | output | 1 | Sink word valid (one cycle) |
| snk_data_o | output | 16 | Word handed to the sink |
| func_o | output | 16 | Function register |

## Verification
All sixteen equipment codes are swept against each of the four request kinds, with bits 15:11 and 6:1 filled with a pattern that changes per code. This shows that only the matching code responds and that the ignored bits cannot block or cause a match. The four kinds are then repeated with the unit not ready, and with protection under both settings of the grant line. These runs separate the status read, which is always replied, from the other three kinds. Empty-source, full-sink and low-byte-versus-full-word reads isolate the flow-control rejects and the byte indicator. Each accepted exchange also holds the strobe longer than needed, which checks the hold, drop and release timing.

// File: rtl/chan_pkg.sv
package chan_pkg;

    typedef enum logic [1:0] {
        OP_DATA_RD = 2'd0,
        OP_DATA_WR = 2'd1,
        OP_STAT_RD = 2'd2,
        OP_FUNC_WR = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_DRV   = 3'd2,
        ST_REPLY = 3'd3,
        ST_DONE  = 3'd4,
        ST_REJ   = 3'd5
    } state_e;

    function automatic logic op_is_read(op_e op);
        return (op == OP_DATA_RD) || (op == OP_STAT_RD);
    endfunction

endpackage

// File: rtl/chan_decode.sv
module chan_decode
    import chan_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int EQ_LSB = 7,
    parameter int EQ_W   = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [EQ_W-1:0]   dev_num_i,
    output logic              hit_o,
    output op_e               op_o
);
    logic match;
    logic dir;

    always_comb begin
        match = (addr_i[EQ_LSB +: EQ_W] == dev_num_i);
        dir   = addr_i[0];
        hit_o = match && (rd_i || wr_i);
        if (rd_i) op_o = dir ? OP_STAT_RD : OP_DATA_RD;
        else      op_o = dir ? OP_FUNC_WR : OP_DATA_WR;
    end
endmodule

// File: rtl/chan_gate.sv
module chan_gate
    import chan_pkg::*;
(
    input  op_e  op_i,
    input  logic dev_ready_i,
    input  logic dev_protected_i,
    input  logic prot_allow_i,
    input  logic src_valid_i,
    input  logic snk_ready_i,
    output logic accept_o
);
    logic guard_ok;
    logic flow_ok;

    always_comb begin
        guard_ok = dev_ready_i && (!dev_protected_i || prot_allow_i);
        unique case (op_i)
            OP_DATA_RD: flow_ok = src_valid_i;
            OP_DATA_WR: flow_ok = snk_ready_i;
            default:    flow_ok = 1'b1;
        endcase
        accept_o = (op_i == OP_STAT_RD) ? 1'b1 : (guard_ok && flow_ok);
    end
endmodule

// File: rtl/chan_seq.sv
module chan_seq
    import chan_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int RESP_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_i,
    input  op_e               op_i,
    input  logic              accept_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] dat_i,
    input  logic [DATA_W-1:0] src_word_i,
    input  logic [DATA_W-1:0] status_i,
    output logic [DATA_W-1:0] dat_o,
    output logic              dat_oe_o,
    output logic              reply_o,
    output logic              reject_o,
    output logic              char_o,
    output logic              src_ready_o,
    output logic              snk_valid_o,
    output logic [DATA_W-1:0] snk_data_o,
    output logic [DATA_W-1:0] func_o
);
    localparam int CW = (RESP_DLY > 1) ? $clog2(RESP_DLY) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(RESP_DLY - 1);

    typedef struct packed {
        state_e            st;
        op_e               op;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] word;
        logic [DATA_W-1:0] func;
        logic              pop;
        logic              push;
    } seq_t;

    seq_t q, d;
    logic strobe;

    always_comb begin
        d        = q;
        d.pop    = 1'b0;
        d.push   = 1'b0;
        strobe   = op_is_read(q.op) ? rd_i : wr_i;
        unique case (q.st)
            ST_IDLE: begin
                if (hit_i) begin
                    d.st  = ST_WAIT;
                    d.op  = op_i;
                    d.cnt = '0;
                end
            end
            ST_WAIT: begin
                if (!strobe) begin
                    d.st = ST_IDLE;
                end else if (q.cnt == CNT_LAST) begin
                    if (!accept_i) begin
                        d.st = ST_REJ;
                    end else begin
                        unique case (q.op)
                            OP_DATA_RD: begin
                                d.st   = ST_DRV;
                                d.word = src_word_i;
                                d.pop  = 1'b1;
                            end
                            OP_STAT_RD: begin
                                d.st   = ST_DRV;
                                d.word = status_i;
                            end
                            OP_DATA_WR: begin
                                d.st   = ST_REPLY;
                                d.word = dat_i;
                                d.push = 1'b1;
                            end
                            default: begin
                                d.st   = ST_REPLY;
                                d.func = dat_i;
                            end
                        endcase
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_DRV:   d.st = ST_REPLY;
            ST_REPLY: if (!strobe) d.st = ST_DONE;
            ST_DONE:  d.st = ST_IDLE;
            ST_REJ:   if (!strobe) d.st = ST_IDLE;
            default:  d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.op   <= OP_DATA_RD;
            q.cnt  <= '0;
            q.word <= '0;
            q.func <= '0;
            q.pop  <= 1'b0;
            q.push <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reply_o     = (q.st == ST_REPLY);
        reject_o    = (q.st == ST_REJ);
        dat_oe_o    = (q.st == ST_DRV) ||
                      (op_is_read(q.op) && ((q.st == ST_REPLY) || (q.st == ST_DONE)));
        dat_o       = dat_oe_o ? q.word : '0;
        char_o      = dat_oe_o && (q.op == OP_DATA_RD) && (q.word[DATA_W-1:8] == '0);
        src_ready_o = q.pop;
        snk_valid_o = q.push;
        snk_data_o  = q.word;
        func_o      = q.func;
    end

    // R11
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reply_o && reject_o));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_o && (rd_i || wr_i)) |=> reply_o);

    // R4
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reply_o || reject_o) && !rd_i && !wr_i) |=> (!reply_o && !reject_o));

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(reply_o) && dat_oe_o) |=> !dat_oe_o);

    // R3
    lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(reply_o) && rd_i) |-> $past(dat_oe_o));

    // R9
    pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready_o |=> !src_ready_o);
endmodule

// File: rtl/chan_responder.sv
module chan_responder
    import chan_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int EQ_LSB    = 7,
    parameter int EQ_W      = 4,
    parameter int RESP_DLY  = 2,
    parameter bit BYTE_ONLY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic              prot_allow_i,
    input  logic [DATA_W-1:0] dat_i,
    output logic [DATA_W-1:0] dat_o,
    output logic              dat_oe_o,
    output logic              reply_o,
    output logic              reject_o,
    output logic              char_o,
    input  logic [EQ_W-1:0]   dev_num_i,
    input  logic              dev_ready_i,
    input  logic              dev_protected_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic              src_valid_i,
    input  logic [DATA_W-1:0] src_data_i,
    output logic              src_ready_o,
    input  logic              snk_ready_i,
    output logic              snk_valid_o,
    output logic [DATA_W-1:0] snk_data_o,
    output logic [DATA_W-1:0] func_o
);
    logic              hit;
    op_e               op;
    logic              accept;
    logic [DATA_W-1:0] src_word;

    generate
        if (BYTE_ONLY) begin : g_byte
            assign src_word = {{(DATA_W-8){1'b0}}, src_data_i[7:0]};
        end else begin : g_word
            assign src_word = src_data_i;
        end
    endgenerate

    chan_decode #(
        .ADDR_W (ADDR_W),
        .EQ_LSB (EQ_LSB),
        .EQ_W   (EQ_W)
    ) u_decode (
        .addr_i    (addr_i),
        .rd_i      (rd_i),
        .wr_i      (wr_i),
        .dev_num_i (dev_num_i),
        .hit_o     (hit),
        .op_o      (op)
    );

    op_e held_op;

    chan_gate u_gate (
        .op_i            (held_op),
        .dev_ready_i     (dev_ready_i),
        .dev_protected_i (dev_protected_i),
        .prot_allow_i    (prot_allow_i),
        .src_valid_i     (src_valid_i),
        .snk_ready_i     (snk_ready_i),
        .accept_o        (accept)
    );

    // The gate judges the request kind that the decoder reports now; the master
    // keeps the address stable for the whole exchange.
    assign held_op = op;

    chan_seq #(
        .DATA_W   (DATA_W),
        .RESP_DLY (RESP_DLY)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit),
        .op_i        (op),
        .accept_i    (accept),
        .rd_i        (rd_i),
        .wr_i        (wr_i),
        .dat_i       (dat_i),
        .src_word_i  (src_word),
        .status_i    (status_i),
        .dat_o       (dat_o),
        .dat_oe_o    (dat_oe_o),
        .reply_o     (reply_o),
        .reject_o    (reject_o),
        .char_o      (char_o),
        .src_ready_o (src_ready_o),
        .snk_valid_o (snk_valid_o),
        .snk_data_o  (snk_data_o),
        .func_o      (func_o)
    );

    // R8
    prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(reply_o) && dev_protected_i && !prot_allow_i) |-> (rd_i && addr_i[0]));

    // R7
    ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(reply_o) && !dev_ready_i) |-> (rd_i && addr_i[0]));

    // R1
    nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(reply_o) || $rose(reject_o)) |-> (addr_i[EQ_LSB +: EQ_W] == dev_num_i));
endmodule

// File: tb/sim_chan_responder.sv
`timescale 1ns/1ps
module sim_chan_responder;
    localparam int DLY = 2;
    localparam logic [3:0] DEV = 4'hB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr_i = '0;
    logic        rd_i = 1'b0, wr_i = 1'b0, prot_allow_i = 1'b0;
    logic [15:0] dat_i = '0;
    logic [15:0] dat_o;
    logic        dat_oe_o, reply_o, reject_o, char_o;
    logic        dev_ready_i = 1'b1, dev_protected_i = 1'b0;
    logic [15:0] status_i = 16'h0129;
    logic        src_valid_i = 1'b1;
    logic [15:0] src_data_i = 16'h3C5A;
    logic        src_ready_o;
    logic        snk_ready_i = 1'b1;
    logic        snk_valid_o;
    logic [15:0] snk_data_o, func_o;

    always #2.5 clk = ~clk;

    chan_responder #(.RESP_DLY(DLY)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
        .prot_allow_i(prot_allow_i), .dat_i(dat_i), .dat_o(dat_o), .dat_oe_o(dat_oe_o),
        .reply_o(reply_o), .reject_o(reject_o), .char_o(char_o), .dev_num_i(DEV),
        .dev_ready_i(dev_ready_i), .dev_protected_i(dev_protected_i), .status_i(status_i),
        .src_valid_i(src_valid_i), .src_data_i(src_data_i), .src_ready_o(src_ready_o),
        .snk_ready_i(snk_ready_i), .snk_valid_o(snk_valid_o), .snk_data_o(snk_data_o),
        .func_o(func_o)
    );

    int vectors = 0;
    int fails = 0;
    int pops = 0;
    int pushes = 0;
    logic [15:0] last_sink = '0;

    always @(negedge clk) begin
        if (src_ready_o) pops++;
        if (snk_valid_o) begin
            pushes++;
            last_sink = snk_data_o;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // results of the last exchange
    int          r_lat;
    bit          r_rep, r_rej, r_chr, r_oe, r_any, r_hold, r_post, r_oe1, r_oe2;
    logic [15:0] r_dat;

    task automatic xfer(input bit is_rd, input logic [15:0] a, input logic [15:0] w,
                        input int hold);
        @(negedge clk);
        addr_i = a; dat_i = w; rd_i = is_rd; wr_i = !is_rd;
        r_lat = 0; r_rep = 0; r_rej = 0; r_chr = 0; r_oe = 0; r_any = 0; r_dat = '0;
        r_hold = 1;
        for (int i = 1; i <= DLY + 6; i++) begin
            @(negedge clk);
            if (dat_oe_o) r_any = 1;
            if (reply_o || reject_o) begin
                r_lat = i; r_rep = reply_o; r_rej = reject_o;
                r_dat = dat_o; r_chr = char_o; r_oe = dat_oe_o;
                break;
            end
        end
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (r_rep && !reply_o) r_hold = 0;
            if (r_rej && !reject_o) r_hold = 0;
        end
        rd_i = 1'b0; wr_i = 1'b0;
        @(negedge clk);
        r_post = reply_o || reject_o;
        r_oe1 = dat_oe_o;
        @(negedge clk);
        r_oe2 = dat_oe_o;
        #1;
    endtask

    function automatic logic [15:0] mk_addr(input logic [3:0] eq, input bit dir,
                                            input logic [4:0] hi, input logic [5:0] mid);
        return {hi, eq, mid, dir};
    endfunction

    // expect reply for an accepted request of kind k (0 data rd, 1 status rd, 2 data wr, 3 func wr)
    task automatic run_ok(input int k, input logic [15:0] a, input logic [15:0] w, input string req);
        int p0, s0;
        bit rd;
        p0 = pops; s0 = pushes;
        rd = (k < 2);
        xfer(rd, a, w, 3);
        check(r_rep && !r_rej, req, {r_rep, r_rej}, 2'b10);
        check(r_lat == (rd ? DLY + 2 : DLY + 1), "R3 latency", r_lat, rd ? DLY + 2 : DLY + 1);
        check(r_hold && !r_post, "R4 hold/drop", {r_hold, r_post}, 2'b10);
        if (rd) begin
            check(r_oe && r_oe1 && !r_oe2, "R5 release", {r_oe, r_oe1, r_oe2}, 3'b110);
            check(r_dat == (k == 0 ? src_data_i : status_i), "R9 read word", r_dat,
                  k == 0 ? src_data_i : status_i);
            check(pops - p0 == (k == 0 ? 1 : 0), "R9 pop count", pops - p0, k == 0 ? 1 : 0);
        end else if (k == 2) begin
            check(pushes - s0 == 1 && last_sink == w, "R2 sink word", last_sink, w);
        end else begin
            check(func_o == w && pushes == s0, "R2 function load", func_o, w);
        end
    endtask

    task automatic run_rej(input int k, input logic [15:0] a, input logic [15:0] w, input string req);
        int p0, s0;
        logic [15:0] f0;
        p0 = pops; s0 = pushes; f0 = func_o;
        xfer(k < 2, a, w, 2);
        check(r_rej && !r_rep && r_lat == DLY + 1, req, {r_rep, r_rej, r_lat[3:0]},
              {2'b01, 4'(DLY + 1)});
        check(r_hold && !r_post && !r_any, "R4 reject hold/drop", {r_hold, r_post, r_any}, 3'b100);
        check(pops == p0 && pushes == s0 && func_o == f0, {req, " no side effect"},
              {pops[7:0], pushes[7:0], func_o}, {p0[7:0], s0[7:0], f0});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R12 reset state
        check(!reply_o && !reject_o && !dat_oe_o && !char_o && !src_ready_o && !snk_valid_o
              && func_o == 0, "R12 reset",
              {reply_o, reject_o, dat_oe_o, char_o, src_ready_o, snk_valid_o, func_o}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R1 / R2 / R9 sweep over every equipment code and every request kind
        for (int eq = 0; eq < 16; eq++) begin
            for (int k = 0; k < 4; k++) begin
                logic [15:0] a, w;
                int p0, s0;
                logic [15:0] f0;
                a = mk_addr(4'(eq), (k == 1 || k == 3), 5'(eq * 7 + k), 6'(eq * 13 + 5));
                w = 16'(16'hA000 + eq * 16 + k);
                src_data_i = 16'(16'h3C00 + eq * 3 + k);
                if (4'(eq) == DEV) begin
                    run_ok(k, a, w, "R1 matching code answered");
                end else begin
                    p0 = pops; s0 = pushes; f0 = func_o;
                    xfer(k < 2, a, w, 0);
                    check(r_lat == 0 && !r_any && !r_oe1 && pops == p0 && pushes == s0
                          && func_o == f0, "R1 unmatched silent",
                          {r_lat[3:0], r_any, r_oe1}, 0);
                end
            end
        end

        // R7 not ready
        dev_ready_i = 1'b0;
        run_rej(0, mk_addr(DEV, 0, 5'h1F, 6'h00), 16'h1111, "R7 data read rejected");
        run_ok (1, mk_addr(DEV, 1, 5'h00, 6'h3F), 16'h0, "R7 status read replied");
        run_rej(2, mk_addr(DEV, 0, 5'h0A, 6'h15), 16'h2222, "R7 data write rejected");
        run_rej(3, mk_addr(DEV, 1, 5'h15, 6'h2A), 16'h3333, "R7 function write rejected");
        dev_ready_i = 1'b1;

        // R8 protection
        dev_protected_i = 1'b1;
        prot_allow_i = 1'b0;
        run_rej(0, mk_addr(DEV, 0, 5'h00, 6'h00), 16'h4444, "R8 data read rejected");
        run_ok (1, mk_addr(DEV, 1, 5'h00, 6'h00), 16'h0, "R8 status read replied");
        run_rej(2, mk_addr(DEV, 0, 5'h00, 6'h00), 16'h5555, "R8 data write rejected");
        run_rej(3, mk_addr(DEV, 1, 5'h00, 6'h00), 16'h6666, "R8 function write rejected");
        prot_allow_i = 1'b1;
        src_data_i = 16'h7E81;
        run_ok(0, mk_addr(DEV, 0, 5'h03, 6'h01), 16'h0, "R8 granted data read");
        run_ok(2, mk_addr(DEV, 0, 5'h03, 6'h01), 16'h7777, "R8 granted data write");
        run_ok(3, mk_addr(DEV, 1, 5'h03, 6'h01), 16'h0888, "R8 granted function write");
        dev_protected_i = 1'b0; prot_allow_i = 1'b0;

        // R6 flow control
        src_valid_i = 1'b0;
        run_rej(0, mk_addr(DEV, 0, 5'h00, 6'h00), 16'h0, "R6 empty source rejected");
        src_valid_i = 1'b1;
        snk_ready_i = 1'b0;
        run_rej(2, mk_addr(DEV, 0, 5'h00, 6'h00), 16'h9999, "R6 full sink rejected");
        snk_ready_i = 1'b1;

        // R10 byte indicator
        src_data_i = 16'h00A5;
        xfer(1'b1, mk_addr(DEV, 0, 5'h00, 6'h00), 16'h0, 0);
        check(r_rep && r_chr && r_dat == 16'h00A5, "R10 low byte word", {r_chr, r_dat}, {1'b1, 16'h00A5});
        src_data_i = 16'h12A5;
        xfer(1'b1, mk_addr(DEV, 0, 5'h00, 6'h00), 16'h0, 0);
        check(r_rep && !r_chr, "R10 full word", r_chr, 0);
        status_i = 16'h0009;
        xfer(1'b1, mk_addr(DEV, 1, 5'h00, 6'h00), 16'h0, 0);
        check(r_rep && !r_chr && r_dat == 16'h0009, "R10 status read", r_chr, 0);
        // R11 exclusivity observed across the run
        check(!(reply_o && reject_o), "R11 exclusive", {reply_o, reject_o}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule